// File: doc/BRIEF.md
# Mode-Switched Strobed Output Port

This block is an eight-bit output port. Its function depends on an operating mode that is captured once, at the first clock after reset is released. In single-chip mode the port is a CPU-writable output register. Reading it back returns the value the output pins are being driven with. An optional strobe feature raises a one-bus-cycle pulse on a dedicated pin after every CPU write to the port. The strobe can be active high or active low.

In expanded mode the eight pins carry the upper byte of the internal address bus on every bus cycle, which lets an external device latch the high address. In this mode the port register is no longer decoded on chip. An access to its address is flagged as going to the external bus. No internal read data or strobe is produced for it.

Top module: `strobed_out_port`

## Requirements
- R1: While reset is asserted and after it is released, the data register is zero, the pins show zero in single-chip mode, the strobe pin is at its inactive level and no internal read hit is reported.
- R2: In single-chip mode, a write with the bus-cycle enable high and the address equal to PORT_ADDR loads the write data onto the pins. A write to any other address, or a write while the enable is low, leaves the pins unchanged.
- R3: In single-chip mode, a read at PORT_ADDR asserts rd_hit_o and returns the value driven on the pins. A read at any other address gives rd_hit_o low and rdata_o zero.
- R4: With the strobe feature enabled, a port write in one bus cycle makes the strobe active for exactly the following bus cycle, including any clocks in which the enable is low. The strobe is inactive afterwards.
- R5: With the strobe feature disabled, port writes leave the strobe pin at its inactive level.
- R6: strb_pol_i = 1 makes the strobe active high (inactive 0). strb_pol_i = 0 makes it active low (inactive 1).
- R7: Port writes in two consecutive bus cycles give two strobe pulses, each one bus cycle long, separated by exactly one inactive bus cycle. The second value is on the pins.
- R8: In expanded mode, pins 7 to 0 follow address bits 15 to 8 in every bus cycle.
- R9: In expanded mode, a read or write at PORT_ADDR asserts ext_pass_o. It produces no rd_hit_o, zero rdata_o and no strobe pulse.
- R10: The mode (mode_exp_i = 1 expanded, 0 single-chip) is sampled on the first clock edge after reset release. Later changes of mode_exp_i have no effect until the next reset.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_ce_i | input | 1 | Bus-cycle clock enable; state advances only when high |
| mode_exp_i | input | 1 | Mode select captured after reset: 1 expanded, 0 single-chip |
| addr_i | input | 16 | Internal address bus |
| wr_i | input | 1 | CPU write request |
| rd_i | input | 1 | CPU read request |
| wdata_i | input | 8 | CPU write data |
| strb_en_i | input | 1 | Enables the write strobe |
| strb_pol_i | input | 1 | Strobe polarity: 1 active high, 0 active low |
| rdata_o | output | 8 | Read data for the port address, zero otherwise |
| rd_hit_o | output | 1 | The port answered the current read internally |
| ext_pass_o | output | 1 | Port-address access forwarded to the external bus |
| port_o | output | 8 | Output pins |
| strobe_o | output | 1 | Write strobe pin |

## Verification
Port writes are tried at the port address, at a neighbouring address and with the enable low. This separates a correct address and enable decode from one that is too loose. Strobe checks use a single write, two writes in adjacent bus cycles, both polarities and the feature disabled. Together they show whether the pulse length, the idle gap and the queuing of a back-to-back write are right. Two distinct addresses in expanded mode confirm that the pins follow the upper byte rather than a stored value. Changing the mode input after reset, in both modes, shows that the mode is latched once.

// File: rtl/sop_pkg.sv
package sop_pkg;
  typedef enum logic {
    OPM_SINGLE   = 1'b0,
    OPM_EXPANDED = 1'b1
  } opmode_e;
endpackage

// File: rtl/sop_mode_latch.sv
module sop_mode_latch
  import sop_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    mode_pin_i,
  output opmode_e mode_o,
  output logic    locked_o
);
  opmode_e mode_q, mode_d;
  logic    locked_q, locked_d;

  always_comb begin
    mode_d   = mode_q;
    locked_d = 1'b1;
    if (!locked_q) mode_d = mode_pin_i ? OPM_EXPANDED : OPM_SINGLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= OPM_SINGLE;
      locked_q <= 1'b0;
    end else begin
      mode_q   <= mode_d;
      locked_q <= locked_d;
    end
  end

  assign mode_o   = mode_q;
  assign locked_o = locked_q;

  AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    locked_q |=> $stable(mode_q)); // R10
endmodule

// File: rtl/sop_data_reg.sv
module sop_data_reg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] data_o
);
  logic [DATA_W-1:0] data_q, data_d;

  always_comb begin
    data_d = data_q;
    if (load_i) data_d = wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) data_q <= '0;
    else        data_q <= data_d;
  end

  assign data_o = data_q;

  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(data_q)); // R2
endmodule

// File: rtl/sop_strobe_gen.sv
module sop_strobe_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_i,
  input  logic wr_evt_i,
  input  logic clear_i,
  output logic pulse_o
);
  logic pulse_q, pulse_d;
  logic pend_q, pend_d;

  always_comb begin
    pulse_d = pulse_q;
    pend_d  = pend_q;
    if (ce_i) begin
      if (clear_i) begin
        pulse_d = 1'b0;
        pend_d  = 1'b0;
      end else if (pulse_q) begin
        pulse_d = 1'b0;
        pend_d  = pend_q | wr_evt_i;
      end else begin
        pulse_d = wr_evt_i | pend_q;
        pend_d  = wr_evt_i & pend_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_q <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      pulse_q <= pulse_d;
      pend_q  <= pend_d;
    end
  end

  assign pulse_o = pulse_q;

  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_i && pulse_q) |=> !pulse_q); // R4
  AST_PULSE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse_q) |-> $past(wr_evt_i || pend_q)); // R7
endmodule

// File: rtl/strobed_out_port.sv
module strobed_out_port
  import sop_pkg::*;
#(
  parameter int               DATA_W    = 8,
  parameter int               ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 16'h0C04
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_ce_i,
  input  logic              mode_exp_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              strb_en_i,
  input  logic              strb_pol_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rd_hit_o,
  output logic              ext_pass_o,
  output logic [DATA_W-1:0] port_o,
  output logic              strobe_o
);
  localparam int HI_LSB = ADDR_W - DATA_W;

  opmode_e           mode;
  logic              locked;
  logic              is_exp, is_single, sel;
  logic              wr_evt, strb_evt, pulse;
  logic [DATA_W-1:0] data;

  sop_mode_latch u_mode (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_pin_i (mode_exp_i),
    .mode_o     (mode),
    .locked_o   (locked)
  );

  always_comb begin
    is_exp    = locked && (mode == OPM_EXPANDED);
    is_single = locked && (mode == OPM_SINGLE);
    sel       = (addr_i == PORT_ADDR);
    wr_evt    = is_single && bus_ce_i && wr_i && sel;
    strb_evt  = wr_evt && strb_en_i;
  end

  sop_data_reg #(.DATA_W(DATA_W)) u_data (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (wr_evt),
    .wdata_i (wdata_i),
    .data_o  (data)
  );

  sop_strobe_gen u_strb (
    .clk      (clk),
    .rst_n    (rst_n),
    .ce_i     (bus_ce_i),
    .wr_evt_i (strb_evt),
    .clear_i  (is_exp),
    .pulse_o  (pulse)
  );

  genvar gi;
  generate
    for (gi = 0; gi < DATA_W; gi++) begin : g_pin
      assign port_o[gi] = is_exp ? addr_i[HI_LSB + gi] : data[gi];
    end
  endgenerate

  always_comb begin
    rd_hit_o   = is_single && rd_i && sel;
    rdata_o    = rd_hit_o ? port_o : '0;
    ext_pass_o = is_exp && sel && (rd_i || wr_i);
    strobe_o   = strb_pol_i ? pulse : ~pulse;
  end

  AST_READ_IS_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit_o |-> (rdata_o == port_o)); // R3
  AST_NO_STROBE_EXP: assert property (@(posedge clk) disable iff (!rst_n)
    is_exp |=> !pulse); // R9
  AST_NO_HIT_EXP: assert property (@(posedge clk) disable iff (!rst_n)
    ext_pass_o |-> !rd_hit_o); // R9
endmodule

// File: tb/strobed_out_port_test.sv
module strobed_out_port_test;
  localparam logic [15:0] PA = 16'h0C04;

  logic        clk = 1'b0;
  logic        rst_n, bus_ce_i, mode_exp_i, wr_i, rd_i, strb_en_i, strb_pol_i;
  logic [15:0] addr_i;
  logic [7:0]  wdata_i, rdata_o, port_o;
  logic        rd_hit_o, ext_pass_o, strobe_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  strobed_out_port uut (
    .clk(clk), .rst_n(rst_n), .bus_ce_i(bus_ce_i), .mode_exp_i(mode_exp_i),
    .addr_i(addr_i), .wr_i(wr_i), .rd_i(rd_i), .wdata_i(wdata_i),
    .strb_en_i(strb_en_i), .strb_pol_i(strb_pol_i), .rdata_o(rdata_o),
    .rd_hit_o(rd_hit_o), .ext_pass_o(ext_pass_o), .port_o(port_o),
    .strobe_o(strobe_o)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic strb_lvl(input logic active);
    return strb_pol_i ? active : ~active;
  endfunction

  task automatic do_reset(input logic m);
    rst_n = 1'b0; mode_exp_i = m; bus_ce_i = 1'b0; wr_i = 1'b0; rd_i = 1'b0;
    addr_i = 16'h0000; wdata_i = 8'h00;
    repeat (3) @(negedge clk);
    chk("R1 reset pins", {8'h00, port_o}, 16'h0000);
    chk("R1 reset strobe", {15'h0, strobe_o}, {15'h0, strb_lvl(1'b0)});
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    mode_exp_i = ~m;
  endtask

  task automatic do_cycle(input logic ce, input logic w, input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_ce_i = ce; wr_i = w; addr_i = a; wdata_i = d;
    @(negedge clk);
    bus_ce_i = 1'b0; wr_i = 1'b0;
  endtask

  task automatic t_reset;
    strb_pol_i = 1'b1; strb_en_i = 1'b0;
    do_reset(1'b0);
    chk("R1 pins after release", {8'h00, port_o}, 16'h0000);
    chk("R1 strobe after release", {15'h0, strobe_o}, 16'h0000);
    rd_i = 1'b1; addr_i = 16'h0C03; #1;
    chk("R1 no hit", {15'h0, rd_hit_o}, 16'h0000);
    rd_i = 1'b0;
  endtask

  task automatic t_write;
    strb_en_i = 1'b0;
    do_cycle(1'b1, 1'b1, PA, 8'hA5);
    chk("R2 write loads pins", {8'h00, port_o}, 16'h00A5);
    chk("R5 disabled strobe", {15'h0, strobe_o}, 16'h0000);
    do_cycle(1'b1, 1'b1, PA + 16'h1, 8'h3C);
    chk("R2 other address ignored", {8'h00, port_o}, 16'h00A5);
    do_cycle(1'b0, 1'b1, PA, 8'hFF);
    chk("R2 enable low ignored", {8'h00, port_o}, 16'h00A5);
    do_cycle(1'b1, 1'b0, 16'h0000, 8'h00);
    chk("R5 strobe stays inactive", {15'h0, strobe_o}, 16'h0000);
  endtask

  task automatic t_read;
    @(negedge clk);
    rd_i = 1'b1; addr_i = PA; #1;
    chk("R3 read hit", {15'h0, rd_hit_o}, 16'h0001);
    chk("R3 read data", {8'h00, rdata_o}, 16'h00A5);
    chk("R3 no ext pass", {15'h0, ext_pass_o}, 16'h0000);
    addr_i = PA - 16'h1; #1;
    chk("R3 miss hit", {15'h0, rd_hit_o}, 16'h0000);
    chk("R3 miss data", {8'h00, rdata_o}, 16'h0000);
    @(negedge clk);
    rd_i = 1'b0;
  endtask

  task automatic t_strobe;
    strb_en_i = 1'b1; strb_pol_i = 1'b1;
    chk("R4 idle before write", {15'h0, strobe_o}, 16'h0000);
    do_cycle(1'b1, 1'b1, PA, 8'h5A);
    chk("R4 pulse after write", {15'h0, strobe_o}, 16'h0001);
    @(negedge clk);
    chk("R4 pulse spans bus cycle", {15'h0, strobe_o}, 16'h0001);
    do_cycle(1'b1, 1'b0, 16'h0000, 8'h00);
    chk("R4 pulse ends", {15'h0, strobe_o}, 16'h0000);
    chk("R2 strobed write data", {8'h00, port_o}, 16'h005A);
  endtask

  task automatic t_polarity;
    strb_en_i = 1'b1; strb_pol_i = 1'b0; #1;
    chk("R6 active-low idle", {15'h0, strobe_o}, 16'h0001);
    do_cycle(1'b1, 1'b1, PA, 8'h11);
    chk("R6 active-low pulse", {15'h0, strobe_o}, 16'h0000);
    do_cycle(1'b1, 1'b0, 16'h0000, 8'h00);
    chk("R6 active-low return", {15'h0, strobe_o}, 16'h0001);
    strb_pol_i = 1'b1;
  endtask

  task automatic t_b2b;
    strb_en_i = 1'b1; strb_pol_i = 1'b1;
    do_cycle(1'b1, 1'b1, PA, 8'h21);
    chk("R7 first pulse", {15'h0, strobe_o}, 16'h0001);
    do_cycle(1'b1, 1'b1, PA, 8'h42);
    chk("R7 idle gap", {15'h0, strobe_o}, 16'h0000);
    chk("R7 second value", {8'h00, port_o}, 16'h0042);
    do_cycle(1'b1, 1'b0, 16'h0000, 8'h00);
    chk("R7 second pulse", {15'h0, strobe_o}, 16'h0001);
    do_cycle(1'b1, 1'b0, 16'h0000, 8'h00);
    chk("R7 after second pulse", {15'h0, strobe_o}, 16'h0000);
  endtask

  task automatic t_expanded;
    strb_en_i = 1'b1; strb_pol_i = 1'b1;
    do_reset(1'b1);
    @(negedge clk);
    bus_ce_i = 1'b1; addr_i = 16'hBEEF; #1;
    chk("R8 high byte BE", {8'h00, port_o}, 16'h00BE);
    @(negedge clk);
    addr_i = 16'h1234; #1;
    chk("R8 high byte 12", {8'h00, port_o}, 16'h0012);
    chk("R10 mode kept expanded", {8'h00, port_o}, 16'h0012);
    @(negedge clk);
    addr_i = PA; wr_i = 1'b1; wdata_i = 8'h99; #1;
    chk("R9 write passed out", {15'h0, ext_pass_o}, 16'h0001);
    chk("R8 pins on port access", {8'h00, port_o}, 16'h000C);
    @(negedge clk);
    wr_i = 1'b0; rd_i = 1'b1; #1;
    chk("R9 no strobe", {15'h0, strobe_o}, 16'h0000);
    chk("R9 no internal hit", {15'h0, rd_hit_o}, 16'h0000);
    chk("R9 read data zero", {8'h00, rdata_o}, 16'h0000);
    chk("R9 read passed out", {15'h0, ext_pass_o}, 16'h0001);
    @(negedge clk);
    rd_i = 1'b0; bus_ce_i = 1'b0;
  endtask

  task automatic t_lock_single;
    strb_en_i = 1'b0;
    do_reset(1'b0);
    do_cycle(1'b1, 1'b1, PA, 8'h77);
    chk("R10 single mode kept", {8'h00, port_o}, 16'h0077);
    @(negedge clk);
    addr_i = 16'hFF00; #1;
    chk("R10 pins ignore address", {8'h00, port_o}, 16'h0077);
  endtask

  initial begin
    t_reset();
    t_write();
    t_read();
    t_strobe();
    t_polarity();
    t_b2b();
    t_expanded();
    t_lock_single();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule